// File: doc/BRIEF.md
# Configurable-Sense Interrupt Controller

This block gathers thirty-two interrupt requests into a single latched pending set and routes the enabled ones onto two processor-facing lines: an ordinary request and a critical request. Each source can be set to level or edge detection and to active-high or active-low sense. Requests are held in a pending register until software clears them by writing ones.

A set of small registers sits behind a plain read/write strobe interface with a three-bit offset. The registers are pending, enable, route, sense, detect mode and a read-only enabled-pending view. The block also reports, at every cycle, the number of the most urgent enabled pending source and a flag that says whether any is pending. Source 0 is the most urgent. In register words, source n occupies bit 31-n.

Two copies of the block can be chained. The ordinary output of the second copy drives one input of the first, and software enables that input on the first copy.

Top module: `sense_irq_ctrl`

## Requirements
- R1: Source n is held in register bit 31-n. `top_id_o` gives the smallest source number whose enabled-pending bit is set, and `top_valid_o` is 1 exactly when any enabled-pending bit is set. When none is set, the valid flag is 0 and the id is 0.
- R2: Offset 5 reads the pending register ANDed with the enable register (offset 1). A write to offset 5 changes nothing.
- R3: A write to offset 0 clears each pending bit whose data bit is 1 and leaves the bits written with 0 unchanged. A pending bit falls only through such a write.
- R4: A bit of 0 in the detect-mode register (offset 4) selects level detection. The pending bit is set on every cycle in which the source is at its active level, so a clear has no lasting effect while the source stays active.
- R5: A bit of 1 in the detect-mode register selects edge detection. The pending bit is set once, on the cycle a qualifying transition is sampled against the registered previous input. A source held steady does not set it again after a clear.
- R6: A sense-register bit (offset 3) of 1 means active high or rising edge. A bit of 0 means active low or falling edge.
- R7: When a source sets a pending bit in the same cycle that a write clears it, the bit ends up set.
- R8: `irq_crit_o` is the registered OR of the enabled-pending bits whose route bit (offset 2) is 1. `irq_norm_o` is the registered OR of those whose route bit is 0. Both outputs change one cycle after the pending bit, and both stay low when all enable bits were 0 on the cycle before.
- R9: After reset, the pending, enable, route and detect-mode registers are 0 and the sense register is all ones. Both request outputs and the valid flag are 0.
- R10: A read strobe at offsets 0 to 5 returns that register on `reg_rdata_o` after the next clock edge. Offsets 6 and 7 read as 0.
- R11: When the ordinary output of a second instance drives source 31 of a first instance, and only that source is enabled on the first, the first instance reports source 31 three cycles after the second instance's source goes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 32 | Interrupt sources, index = source number |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid one cycle after the strobe |
| irq_norm_o | output | 1 | Ordinary interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |
| top_valid_o | output | 1 | Some enabled source is pending |
| top_id_o | output | 5 | Number of the most urgent enabled pending source |

## Verification
The properties assume that every source is synchronous to the clock and inactive while reset is held. The level-sticky check compares the sources sampled on the cycle before against the pending register, so a source that was active during reset would appear to break it on the first cycle after release. The bench holds all sources low through reset and changes them only on falling clock edges, which keeps every input stable across the sampling edge. The chained source in the cascade test is the registered output of the second instance, so it meets the same condition.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PEND  = 3'd0,
    REG_ENA   = 3'd1,
    REG_ROUTE = 3'd2,
    REG_SENSE = 3'd3,
    REG_MODE  = 3'd4,
    REG_MPEND = 3'd5
  } sic_reg_e;
endpackage

// File: rtl/sic_detect.sv
module sic_detect #(
  parameter int NSRC = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] sense_i,
  input  logic [NSRC-1:0] mode_i,
  output logic [NSRC-1:0] set_o
);
  logic [NSRC-1:0] src_bits;
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] prev_d;

  // source n lands on register bit NSRC-1-n
  for (genvar g = 0; g < NSRC; g++) begin : g_map
    assign src_bits[NSRC-1-g] = src_i[g];
  end

  assign prev_d = src_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= prev_d;
  end

  for (genvar b = 0; b < NSRC; b++) begin : g_bit
    logic at_level;
    logic moved;
    always_comb begin
      at_level = (src_bits[b] == sense_i[b]);
      moved    = (src_bits[b] != prev_q[b]);
      set_o[b] = mode_i[b] ? (at_level & moved) : at_level;
    end
  end
endmodule

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   wdata_i,
  input  logic [NSRC-1:0]   set_i,
  output logic [NSRC-1:0]   pend_o,
  output logic [NSRC-1:0]   ena_o,
  output logic [NSRC-1:0]   route_o,
  output logic [NSRC-1:0]   sense_o,
  output logic [NSRC-1:0]   mode_o,
  output logic [NSRC-1:0]   rdata_o
);
  logic [NSRC-1:0] pend_q, pend_d;
  logic [NSRC-1:0] ena_q, ena_d;
  logic [NSRC-1:0] route_q, route_d;
  logic [NSRC-1:0] sense_q, sense_d;
  logic [NSRC-1:0] mode_q, mode_d;
  logic [NSRC-1:0] rdata_q, rdata_d;
  logic [NSRC-1:0] clr_mask;
  sic_reg_e        sel;

  assign sel = sic_reg_e'(addr_i);

  always_comb begin
    clr_mask = (wr_i && sel == REG_PEND) ? wdata_i : '0;
    // set has priority over the clear of the same cycle
    pend_d   = (pend_q & ~clr_mask) | set_i;
    ena_d    = (wr_i && sel == REG_ENA)   ? wdata_i : ena_q;
    route_d  = (wr_i && sel == REG_ROUTE) ? wdata_i : route_q;
    sense_d  = (wr_i && sel == REG_SENSE) ? wdata_i : sense_q;
    mode_d   = (wr_i && sel == REG_MODE)  ? wdata_i : mode_q;
    case (sel)
      REG_PEND:  rdata_d = pend_q;
      REG_ENA:   rdata_d = ena_q;
      REG_ROUTE: rdata_d = route_q;
      REG_SENSE: rdata_d = sense_q;
      REG_MODE:  rdata_d = mode_q;
      REG_MPEND: rdata_d = pend_q & ena_q;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      ena_q   <= '0;
      route_q <= '0;
      sense_q <= '1;
      mode_q  <= '0;
      rdata_q <= '0;
    end else begin
      pend_q  <= pend_d;
      ena_q   <= ena_d;
      route_q <= route_d;
      sense_q <= sense_d;
      mode_q  <= mode_d;
      if (rd_i) rdata_q <= rdata_d;
    end
  end

  assign pend_o  = pend_q;
  assign ena_o   = ena_q;
  assign route_o = route_q;
  assign sense_o = sense_q;
  assign mode_o  = mode_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/sic_prio.sv
module sic_prio #(
  parameter int NSRC = 32,
  localparam int ID_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] mpend_i,
  output logic            valid_o,
  output logic [ID_W-1:0] id_o
);
  // walk from the least urgent source to the most urgent; the last hit wins
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    for (int n = NSRC - 1; n >= 0; n--) begin
      if (mpend_i[NSRC-1-n]) begin
        valid_o = 1'b1;
        id_o    = ID_W'(n);
      end
    end
  end
endmodule

// File: rtl/sense_irq_ctrl.sv
module sense_irq_ctrl
  import sic_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int ID_W = $clog2(NSRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   irq_src_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [NSRC-1:0]   reg_wdata_i,
  output logic [NSRC-1:0]   reg_rdata_o,
  output logic              irq_norm_o,
  output logic              irq_crit_o,
  output logic              top_valid_o,
  output logic [ID_W-1:0]   top_id_o
);
  logic [NSRC-1:0] set_bits;
  logic [NSRC-1:0] status_q;
  logic [NSRC-1:0] enable_q;
  logic [NSRC-1:0] route_q;
  logic [NSRC-1:0] sense_q;
  logic [NSRC-1:0] mode_q;
  logic [NSRC-1:0] mpend;
  logic            norm_d, crit_d;
  logic            norm_q, crit_q;

  sic_detect #(.NSRC(NSRC)) u_detect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (irq_src_i),
    .sense_i (sense_q),
    .mode_i  (mode_q),
    .set_o   (set_bits)
  );

  sic_regs #(.NSRC(NSRC)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .rd_i    (reg_rd_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .set_i   (set_bits),
    .pend_o  (status_q),
    .ena_o   (enable_q),
    .route_o (route_q),
    .sense_o (sense_q),
    .mode_o  (mode_q),
    .rdata_o (reg_rdata_o)
  );

  assign mpend = status_q & enable_q;

  sic_prio #(.NSRC(NSRC)) u_prio (
    .mpend_i (mpend),
    .valid_o (top_valid_o),
    .id_o    (top_id_o)
  );

  always_comb begin
    norm_d = |(mpend & ~route_q);
    crit_d = |(mpend & route_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      norm_q <= 1'b0;
      crit_q <= 1'b0;
    end else begin
      norm_q <= norm_d;
      crit_q <= crit_d;
    end
  end

  assign irq_norm_o = norm_q;
  assign irq_crit_o = crit_q;
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
  parameter int NSRC = 32,
  localparam int ID_W = $clog2(NSRC)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-1:0] src_i,
  input logic            wr_i,
  input logic [2:0]      addr_i,
  input logic [NSRC-1:0] wdata_i,
  input logic [NSRC-1:0] status_i,
  input logic [NSRC-1:0] enable_i,
  input logic [NSRC-1:0] sense_i,
  input logic [NSRC-1:0] mode_i,
  input logic            norm_i,
  input logic            crit_i,
  input logic            valid_i,
  input logic [ID_W-1:0] id_i
);
  logic [NSRC-1:0] mpend;
  logic [NSRC-1:0] above;
  logic [NSRC-1:0] lvl_active;
  logic [NSRC-1:0] clr_mask;

  always_comb begin
    mpend    = status_i & enable_i;
    clr_mask = (wr_i && addr_i == 3'd0) ? wdata_i : '0;
    for (int b = 0; b < NSRC; b++) begin
      above[b]      = (b > (NSRC - 1 - int'(id_i)));
      lvl_active[b] = !mode_i[b] && (src_i[NSRC-1-b] == sense_i[b]);
    end
  end

  // R1: the reported source is pending
  a_r1_id_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> mpend[NSRC-1-int'(id_i)]);

  // R1: no more urgent source is pending
  a_r1_none_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ((mpend & above) == '0));

  // R3: pending bits fall only where a clear write put a one
  a_r3_clear_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(status_i) & ~status_i) & ~$past(clr_mask)) == '0));

  // R4, R7: an active level source is pending on the next cycle
  a_r4_level_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_i & $past(lvl_active)) == $past(lvl_active)));

  // R8: nothing enabled, no request on the next cycle
  a_r8_quiet_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i == '0) |=> (!norm_i && !crit_i));
endmodule

bind sense_irq_ctrl sic_checker #(.NSRC(NSRC)) u_sic_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .src_i    (irq_src_i),
  .wr_i     (reg_wr_i),
  .addr_i   (reg_addr_i),
  .wdata_i  (reg_wdata_i),
  .status_i (status_q),
  .enable_i (enable_q),
  .sense_i  (sense_q),
  .mode_i   (mode_q),
  .norm_i   (irq_norm_o),
  .crit_i   (irq_crit_o),
  .valid_i  (top_valid_o),
  .id_i     (top_id_o)
);

// File: tb/sense_irq_ctrl_test.sv
module sense_irq_ctrl_test;
  logic        clk;
  logic        rst_n;
  logic [30:0] tb_src;
  logic [31:0] tb_src2;
  logic        bus_wr, bus_rd, bus_tgt;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] rdata1, rdata2;
  logic        norm1, crit1, valid1, norm2, crit2, valid2;
  logic [4:0]  id1, id2;
  logic [31:0] rv;
  int          n_chk, n_err;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  sense_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i({norm2, tb_src}),
    .reg_wr_i(bus_wr & ~bus_tgt), .reg_rd_i(bus_rd & ~bus_tgt),
    .reg_addr_i(bus_addr), .reg_wdata_i(bus_wdata), .reg_rdata_o(rdata1),
    .irq_norm_o(norm1), .irq_crit_o(crit1), .top_valid_o(valid1), .top_id_o(id1));

  sense_irq_ctrl uut2 (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(tb_src2),
    .reg_wr_i(bus_wr & bus_tgt), .reg_rd_i(bus_rd & bus_tgt),
    .reg_addr_i(bus_addr), .reg_wdata_i(bus_wdata), .reg_rdata_o(rdata2),
    .irq_norm_o(norm2), .irq_crit_o(crit2), .top_valid_o(valid2), .top_id_o(id2));

  function automatic logic [31:0] bit_of(input int n);
    return 32'h1 << (31 - n);
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic t, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_tgt = t; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic t, input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_tgt = t; bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = t ? rdata2 : rdata1;
  endtask

  // {source pattern [30:0], expected valid, expected id}
  localparam logic [36:0] VEC [8] = '{
    {31'h0000_0000, 1'b0, 5'd0},
    {31'h0000_0001, 1'b1, 5'd0},
    {31'h4000_0000, 1'b1, 5'd30},
    {31'h0000_0220, 1'b1, 5'd5},
    {31'h2002_0008, 1'b1, 5'd3},
    {31'h7FFF_FFFF, 1'b1, 5'd0},
    {31'h0000_3000, 1'b1, 5'd12},
    {31'h0000_0002, 1'b1, 5'd1}
  };

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; tb_src = '0; tb_src2 = '0;
    bus_wr = 0; bus_rd = 0; bus_tgt = 0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state, read through R10
    chk("R9 outputs", {29'd0, norm1, crit1, valid1}, 32'h0);
    rd(0, 3'd0, rv); chk("R9 pending", rv, 32'h0);
    rd(0, 3'd1, rv); chk("R9 enable", rv, 32'h0);
    rd(0, 3'd2, rv); chk("R9 route", rv, 32'h0);
    rd(0, 3'd3, rv); chk("R9 sense", rv, 32'hFFFF_FFFF);
    rd(0, 3'd4, rv); chk("R9 mode", rv, 32'h0);
    rd(0, 3'd7, rv); chk("R10 unused offset", rv, 32'h0);

    // R1 priority table, level active-high sources, all enabled
    wr(0, 3'd1, 32'hFFFF_FFFF);
    rd(0, 3'd1, rv); chk("R10 enable readback", rv, 32'hFFFF_FFFF);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      tb_src = VEC[v][36:6];
      @(negedge clk);
      chk($sformatf("R1 vec%0d valid", v), {31'd0, valid1}, {31'd0, VEC[v][5]});
      chk($sformatf("R1 vec%0d id", v), {27'd0, id1}, {27'd0, VEC[v][4:0]});
      rd(0, 3'd5, rv);
      chk($sformatf("R1 vec%0d bit order", v), rv, rev32({1'b0, VEC[v][36:6]}));
      tb_src = '0;
      wr(0, 3'd0, 32'hFFFF_FFFF);
    end

    // R2 masked view and read-only offset
    wr(0, 3'd1, bit_of(4));
    @(negedge clk); tb_src = 31'h14;
    @(negedge clk); tb_src = '0;
    rd(0, 3'd0, rv); chk("R2 pending", rv, bit_of(2) | bit_of(4));
    rd(0, 3'd5, rv); chk("R2 masked", rv, bit_of(4));
    chk("R2 id", {27'd0, id1}, 32'd4);
    wr(0, 3'd5, 32'h0);
    rd(0, 3'd5, rv); chk("R2 write ignored", rv, bit_of(4));

    // R3 write-one-to-clear
    wr(0, 3'd0, bit_of(2));
    rd(0, 3'd0, rv); chk("R3 partial clear", rv, bit_of(4));
    wr(0, 3'd0, 32'h0);
    rd(0, 3'd0, rv); chk("R3 zero write keeps", rv, bit_of(4));
    wr(0, 3'd0, 32'hFFFF_FFFF);
    rd(0, 3'd0, rv); chk("R3 clear all", rv, 32'h0);

    // R4 level source re-latches
    @(negedge clk); tb_src[6] = 1'b1;
    wr(0, 3'd0, bit_of(6));
    rd(0, 3'd0, rv); chk("R4 clear while active", rv, bit_of(6));
    @(negedge clk); tb_src[6] = 1'b0;
    wr(0, 3'd0, bit_of(6));
    rd(0, 3'd0, rv); chk("R4 clear after release", rv, 32'h0);

    // R5 edge detection on source 7
    wr(0, 3'd4, bit_of(7));
    @(negedge clk); tb_src[7] = 1'b1;
    @(negedge clk);
    wr(0, 3'd0, 32'hFFFF_FFFF);
    rd(0, 3'd0, rv); chk("R5 held high no reset", rv, 32'h0);
    @(negedge clk); tb_src[7] = 1'b0;
    rd(0, 3'd0, rv); chk("R5 falling ignored", rv, 32'h0);
    @(negedge clk); tb_src[7] = 1'b1;
    rd(0, 3'd0, rv); chk("R5 second rise", rv, bit_of(7));
    @(negedge clk); tb_src[7] = 1'b0;
    wr(0, 3'd0, 32'hFFFF_FFFF);

    // R6 active-low level (source 8) and falling edge (source 9)
    wr(0, 3'd4, bit_of(7) | bit_of(9));
    wr(0, 3'd3, ~(bit_of(8) | bit_of(9)));
    rd(0, 3'd0, rv); chk("R6 active-low level", rv, bit_of(8));
    @(negedge clk); tb_src[8] = 1'b1; tb_src[9] = 1'b1;
    wr(0, 3'd0, 32'hFFFF_FFFF);
    rd(0, 3'd0, rv); chk("R6 rising ignored", rv, 32'h0);
    @(negedge clk); tb_src[9] = 1'b0;
    rd(0, 3'd0, rv); chk("R6 falling edge", rv, bit_of(9));
    @(negedge clk); tb_src = '0;
    wr(0, 3'd3, 32'hFFFF_FFFF);
    wr(0, 3'd0, 32'hFFFF_FFFF);

    // R7 set beats clear in the same cycle
    wr(0, 3'd4, bit_of(11));
    @(negedge clk);
    tb_src[11] = 1'b1;
    bus_tgt = 0; bus_addr = 3'd0; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(0, 3'd0, rv); chk("R7 set wins", rv, bit_of(11));
    @(negedge clk); tb_src = '0;
    wr(0, 3'd4, 32'h0);
    wr(0, 3'd0, 32'hFFFF_FFFF);

    // R8 routing and output delay
    wr(0, 3'd1, bit_of(12) | bit_of(13));
    wr(0, 3'd2, bit_of(12));
    @(negedge clk); tb_src[12] = 1'b1;
    @(negedge clk);
    chk("R8 crit one cycle late", {30'd0, crit1, norm1}, 32'h0);
    @(negedge clk);
    chk("R8 crit routed", {30'd0, crit1, norm1}, 32'h2);
    tb_src[12] = 1'b0;
    wr(0, 3'd0, 32'hFFFF_FFFF);
    @(negedge clk); tb_src[13] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 norm routed", {30'd0, crit1, norm1}, 32'h1);
    tb_src[13] = 1'b0;
    wr(0, 3'd0, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R8 outputs drop", {30'd0, crit1, norm1}, 32'h0);

    // R11 cascade: uut2 source 3 feeds uut source 31
    wr(0, 3'd2, 32'h0);
    wr(0, 3'd1, bit_of(31));
    wr(1, 3'd1, bit_of(3));
    @(negedge clk); tb_src2[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R11 not yet", {31'd0, valid1}, 32'h0);
    @(negedge clk);
    chk("R11 cascade valid", {31'd0, valid1}, 32'h1);
    chk("R11 cascade id", {27'd0, id1}, 32'd31);
    @(negedge clk);
    chk("R11 first norm", {31'd0, norm1}, 32'h1);
    tb_src2 = '0;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule